// File: doc/BRIEF.md
# Status-Coded Two-Wire Master Transmitter

This block is a two-wire (I2C) bus master that sends write transfers for a small processor. Software works through three registers: a control register, a data register and a read-only status register. After each bus event the block stops, puts an event code in the status register and raises an interrupt flag. While the flag is up, the clock line is held low. Software then loads the next byte if one is needed. It clears the flag and, in the same write, uses the start and stop bits to pick the next bus action.

Both lines are open-drain. The block only ever pulls a line low or lets it go, and reads the wired level back through two-flop synchronisers. One bit slot lasts four phases, and each phase lasts `DIV` clock cycles. A line monitor marks the bus busy when it sees a START and free when it sees a STOP.

The control state machine has six states:
- `ST_IDLE`: lines released, waiting for the start bit and a free bus.
- `ST_START`: puts a START or a repeated START on the bus.
- `ST_WAIT`: clock held low until software clears the flag.
- `ST_BYTE`: eight data bits, then the acknowledge slot.
- `ST_STOP`: puts a STOP on the bus.
- `ST_LOST`: both lines released after arbitration was lost.

The transitions are:
- IDLE→START when the start bit is set, the bus is free and the flag is clear.
- START→WAIT at the end of the condition.
- WAIT→BYTE, WAIT→START or WAIT→STOP when software clears the flag.
- BYTE→WAIT after the acknowledge slot.
- BYTE→LOST when a released 1 bit reads back as 0.
- STOP→IDLE when the STOP is complete.
- LOST→IDLE when software clears the flag.

Top module: `twi_xmit_master`

## Requirements
- R1: After reset, the control register reads 00h and the status register reads F8h. Both line outputs are released. The register offsets are: 0 control, 1 data, 2 status, 3 always reads 00h. Control bits are: bit0 start, bit1 stop, bit2 interrupt flag, bit3 acknowledge.
- R2: A START from idle reports status 08h. A START issued from the wait state (repeated START) reports 10h.
- R3: An address byte with bit0 = 0 reports 18h on ACK and 20h on NACK. An address byte with bit0 = 1 reports 40h on ACK and 48h on NACK. When the flag is then cleared with start = stop = 0, the block only sends a STOP.
- R4: A data byte reports 28h on ACK and 30h on NACK. Every byte goes out most significant bit first. In status 08h or 10h, the byte sent next is the content of the data register.
- R5: Each bus event sets the interrupt flag. While the flag is set (other than in 38h), SCL is held low, nothing further happens on the bus and the status does not change. Writing 0 to the flag clears it. Writing 1 leaves it unchanged.
- R6: In statuses 18h, 20h, 28h and 30h, clearing the flag picks the next action from the start and stop bits:
  - start = 0, stop = 0: send the data byte.
  - start = 1, stop = 0: repeated START, reported as 10h.
  - start = 0, stop = 1: STOP.
  - start = 1, stop = 1: STOP followed by a fresh START, reported as 08h.
- R7: The stop bit clears itself once the STOP has been put on the bus. At that point both lines are high.
- R8: A transmitted 1 that reads back as 0 while SCL is high means arbitration was lost. The block reports 38h and releases both SCL and SDA.
- R9: From 38h, clearing the flag with start = 0 leaves the block idle with no further events. With start = 1, the block waits until a STOP has been seen on the bus and then issues a START that reports 08h.
- R10: The status register cannot be written. The acknowledge bit is stored and reads back, but has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | Wired level of the clock line |
| sda_in | input | 1 | Wired level of the data line |
| scl_drive_low | output | 1 | Pull the clock line low when 1 |
| sda_drive_low | output | 1 | Pull the data line low when 1 |

## Verification
The assertions assume that software never clears the stop bit itself while a STOP is pending. They also assume that no other device pulls SCL low while the block has released it. Every line edge caused by another party (slave acknowledge, rival master) happens while SCL is low, except the rival's release that forms a STOP. The stimulus keeps to this: the bench slave model and the rival drive SDA only just after a falling SCL edge. Software writes with the stop bit set only from the wait state, and never writes a 0 over a pending stop.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_BYTE,
        ST_STOP,
        ST_LOST
    } twi_state_e;

    localparam logic [7:0] SC_NONE      = 8'hF8;
    localparam logic [7:0] SC_START     = 8'h08;
    localparam logic [7:0] SC_RESTART   = 8'h10;
    localparam logic [7:0] SC_WADDR_ACK = 8'h18;
    localparam logic [7:0] SC_WADDR_NAK = 8'h20;
    localparam logic [7:0] SC_DATA_ACK  = 8'h28;
    localparam logic [7:0] SC_DATA_NAK  = 8'h30;
    localparam logic [7:0] SC_LOST      = 8'h38;
    localparam logic [7:0] SC_RADDR_ACK = 8'h40;
    localparam logic [7:0] SC_RADDR_NAK = 8'h48;

    localparam logic [1:0] RA_CTRL   = 2'd0;
    localparam logic [1:0] RA_DATA   = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;

endpackage

// File: rtl/twi_tick_gen.sv
module twi_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/twi_bus_watch.sv
module twi_bus_watch #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic bus_free
);
    logic scl_q, sda_q, busy_q;
    logic start_seen, stop_seen;

    generate
        if (SYNC == 0) begin : g_direct
            assign scl_s = scl_in;
            assign sda_s = sda_in;
        end else begin : g_sync
            logic [SYNC-1:0] scl_sh, sda_sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= (scl_sh << 1) | SYNC'(scl_in);
                    sda_sh <= (sda_sh << 1) | SYNC'(sda_in);
                end
            end
            assign scl_s = scl_sh[SYNC-1];
            assign sda_s = sda_sh[SYNC-1];
        end
    endgenerate

    assign start_seen = scl_s && scl_q && sda_q && !sda_s;
    assign stop_seen  = scl_s && scl_q && !sda_q && sda_s;
    assign bus_free   = !busy_q && scl_s && sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            if (start_seen)
                busy_q <= 1'b1;
            else if (stop_seen)
                busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/twi_xmit_master.sv
module twi_xmit_master
    import twi_pkg::*;
#(
    parameter int DIV  = 4,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);
    localparam int         BITS    = 8;
    localparam logic [3:0] ACK_BIT = 4'(BITS);

    logic tick, bus_free, scl_s, sda_s;

    twi_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    twi_bus_watch #(.SYNC(SYNC)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .bus_free(bus_free)
    );

    // register file
    logic       sta_q, stop_q, irq_q, ack_q;
    logic [7:0] data_q, status_q;

    // sequencer state
    twi_state_e state_q;
    logic [1:0] ph_q;
    logic [3:0] bit_q;
    logic [7:0] shift_q;
    logic       rep_q, addr_q, rd_q, ackd_q;

    logic       evt, lost, stop_done;
    logic [7:0] evt_code;

    always_comb begin
        evt      = 1'b0;
        lost     = 1'b0;
        evt_code = status_q;
        if (tick) begin
            if (state_q == ST_START && ph_q == 2'd3) begin
                evt      = 1'b1;
                evt_code = rep_q ? SC_RESTART : SC_START;
            end
            if (state_q == ST_BYTE && ph_q == 2'd2 && bit_q < ACK_BIT
                && shift_q[7] && !sda_s) begin
                evt      = 1'b1;
                lost     = 1'b1;
                evt_code = SC_LOST;
            end
            if (state_q == ST_BYTE && ph_q == 2'd3 && bit_q == ACK_BIT) begin
                evt = 1'b1;
                if (addr_q && rd_q)
                    evt_code = ackd_q ? SC_RADDR_ACK : SC_RADDR_NAK;
                else if (addr_q)
                    evt_code = ackd_q ? SC_WADDR_ACK : SC_WADDR_NAK;
                else
                    evt_code = ackd_q ? SC_DATA_ACK : SC_DATA_NAK;
            end
        end
    end

    assign stop_done = tick && state_q == ST_STOP && ph_q == 2'd3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_q    <= 1'b0;
            stop_q   <= 1'b0;
            irq_q    <= 1'b0;
            ack_q    <= 1'b0;
            data_q   <= '0;
            status_q <= SC_NONE;
        end else begin
            if (reg_we && reg_addr == RA_CTRL) begin
                sta_q  <= reg_wdata[0];
                stop_q <= reg_wdata[1];
                ack_q  <= reg_wdata[3];
                if (!reg_wdata[2])
                    irq_q <= 1'b0;
            end
            if (reg_we && reg_addr == RA_DATA)
                data_q <= reg_wdata;
            if (stop_done)
                stop_q <= 1'b0;
            if (evt) begin
                irq_q    <= 1'b1;
                status_q <= evt_code;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:   reg_rdata = {4'b0, ack_q, irq_q, stop_q, sta_q};
            RA_DATA:   reg_rdata = data_q;
            RA_STATUS: reg_rdata = status_q;
            default:   reg_rdata = 8'h00;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            rep_q   <= 1'b0;
            addr_q  <= 1'b0;
            rd_q    <= 1'b0;
            ackd_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    ph_q <= '0;
                    if (tick && sta_q && bus_free && !irq_q) begin
                        state_q <= ST_START;
                        rep_q   <= 1'b0;
                    end
                end
                ST_START: if (tick) begin
                    if (ph_q == 2'd3) begin
                        state_q <= ST_WAIT;
                        addr_q  <= 1'b1;
                        ph_q    <= '0;
                    end else
                        ph_q <= ph_q + 2'd1;
                end
                ST_WAIT: if (tick && !irq_q) begin
                    ph_q <= '0;
                    if (status_q == SC_START || status_q == SC_RESTART) begin
                        state_q <= ST_BYTE;
                        shift_q <= data_q;
                        rd_q    <= data_q[0];
                        bit_q   <= '0;
                    end else if (stop_q) begin
                        state_q <= ST_STOP;
                    end else if (sta_q) begin
                        state_q <= ST_START;
                        rep_q   <= 1'b1;
                    end else if (status_q == SC_RADDR_ACK || status_q == SC_RADDR_NAK) begin
                        state_q <= ST_STOP;
                    end else begin
                        state_q <= ST_BYTE;
                        shift_q <= data_q;
                        bit_q   <= '0;
                        addr_q  <= 1'b0;
                    end
                end
                ST_BYTE: if (tick) begin
                    if (ph_q == 2'd2) begin
                        if (lost)
                            state_q <= ST_LOST;
                        else if (bit_q == ACK_BIT)
                            ackd_q <= !sda_s;
                        ph_q <= 2'd3;
                    end else if (ph_q == 2'd3) begin
                        ph_q <= '0;
                        if (bit_q == ACK_BIT)
                            state_q <= ST_WAIT;
                        else begin
                            shift_q <= shift_q << 1;
                            bit_q   <= bit_q + 4'd1;
                        end
                    end else
                        ph_q <= ph_q + 2'd1;
                end
                ST_STOP: if (tick) begin
                    if (ph_q == 2'd3) begin
                        state_q <= ST_IDLE;
                        ph_q    <= '0;
                    end else
                        ph_q <= ph_q + 2'd1;
                end
                ST_LOST: if (!irq_q) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // line outputs
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (state_q)
            ST_START: begin
                scl_drive_low = (ph_q == 2'd0 && rep_q) || ph_q == 2'd3;
                sda_drive_low = ph_q >= 2'd2;
            end
            ST_WAIT: begin
                scl_drive_low = 1'b1;
                sda_drive_low = (status_q == SC_START || status_q == SC_RESTART);
            end
            ST_BYTE: begin
                scl_drive_low = ph_q < 2'd2;
                sda_drive_low = (bit_q < ACK_BIT) && !shift_q[7];
            end
            ST_STOP: begin
                scl_drive_low = ph_q == 2'd0;
                sda_drive_low = ph_q != 2'd3;
            end
            default: begin
                scl_drive_low = 1'b0;
                sda_drive_low = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/twi_xmit_checker.sv
module twi_xmit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       stop_bit,
    input logic [7:0] status,
    input logic       scl_low,
    input logic       sda_low
);
    // R5: flag up outside arbitration loss keeps the clock line pulled low
    p_scl_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status != 8'h38) |-> scl_low);

    // R5: status only moves when a new event raises the flag
    p_status_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> $rose(irq));

    // R8: after lost arbitration both lines are let go
    p_lost_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status == 8'h38) |-> (!scl_low && !sda_low));

    // R7: the stop bit drops only when the STOP has left both lines released
    p_stop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_bit) |-> (!scl_low && !sda_low));

    // R2: only defined codes ever appear
    p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28,
                                8'h30, 8'h38, 8'h40, 8'h48}));
endmodule

bind twi_xmit_master twi_xmit_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq_q),
    .stop_bit(stop_q),
    .status  (status_q),
    .scl_low (scl_drive_low),
    .sda_low (sda_drive_low)
);

// File: tb/sim_twi_xmit_master.sv
`timescale 1ns/1ps
module sim_twi_xmit_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dut_scl_low, dut_sda_low;
    logic       slave_sda_low = 1'b0;
    logic       rival_low = 1'b0;
    wire        scl_line = ~dut_scl_low;
    wire        sda_line = ~(dut_sda_low | slave_sda_low | rival_low);

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench slave state
    int bitcnt = 0;
    int byte_idx = 0;
    int nack_idx = -1;
    int stop_cnt = 0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] cap [0:15];
    bit rival_arm = 1'b0;
    int rival_bit = 2;

    always #2 clk = ~clk;

    twi_xmit_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(dut_scl_low), .sda_drive_low(dut_sda_low)
    );

    // START detection
    initial forever begin
        @(negedge sda_line);
        #1;
        if (scl_line && !sda_line) begin
            bitcnt = 0;
            byte_idx = 0;
        end
    end

    // STOP detection
    initial forever begin
        @(posedge sda_line);
        #1;
        if (scl_line && sda_line) stop_cnt++;
    end

    // bit capture on rising SCL
    initial forever begin
        @(posedge scl_line);
        if (bitcnt < 8) begin
            shreg = {shreg[6:0], sda_line};
            bitcnt++;
            if (bitcnt == 8 && byte_idx < 16) cap[byte_idx] = shreg;
        end else
            bitcnt++;
    end

    // acknowledge and rival drive on falling SCL
    initial forever begin
        @(negedge scl_line);
        #1;
        if (bitcnt == 8)
            slave_sda_low = (byte_idx != nack_idx);
        else if (bitcnt == 9) begin
            slave_sda_low = 1'b0;
            bitcnt = 0;
            byte_idx++;
        end
        if (rival_arm && byte_idx == 0 && bitcnt == rival_bit) begin
            rival_low = 1'b1;
            rival_arm = 1'b0;
        end
    end

    function automatic logic [7:0] exp_addr_code(input bit rd, input bit ack);
        if (rd) return ack ? 8'h40 : 8'h48;
        return ack ? 8'h18 : 8'h20;
    endfunction

    function automatic logic [7:0] exp_data_code(input bit ack);
        return ack ? 8'h28 : 8'h30;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        logic [7:0] v;
        int n;
        n = 0;
        v = 8'h00;
        while (n < 4000) begin
            rd(2'd0, v);
            if (v[2]) break;
            n++;
        end
        if (n >= 4000) chk(1'b0, req, 0, 1);
    endtask

    task automatic expect_status(input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(2'd2, v);
        chk(v == e, req, v, e);
    endtask

    task automatic finish_stop(input logic ackb);
        logic [7:0] v;
        int n, s0;
        s0 = stop_cnt;
        wr(2'd0, {4'b0, ackb, 3'b010});
        n = 0;
        v = 8'h02;
        while (n < 2000) begin
            rd(2'd0, v);
            if (!v[1]) break;
            n++;
        end
        repeat (4) @(negedge clk);
        chk(!v[1] && scl_line && sda_line && stop_cnt == s0 + 1,
            "R7 stop bit self-clear", {v[1], scl_line, sda_line}, 3'b011);
    endtask

    // one transfer from status 08h/10h; returns 1 when left waiting after a START
    task automatic txn(input logic [7:0] addr_b, input int nbytes, input int nk,
                       input int fin, input logic ackb, input bit hold_chk,
                       output bit in_wait);
        logic [7:0] v, d;
        int s0;
        nack_idx = nk;
        wr(2'd1, addr_b);
        wr(2'd0, {4'b0, ackb, 3'b000});
        wait_irq("R3 address event");
        expect_status(exp_addr_code(addr_b[0], nk != 0), "R3 address status");
        chk(cap[0] == addr_b, "R4 address bits msb first", cap[0], addr_b);
        if (hold_chk) begin
            bit held;
            held = 1'b1;
            wr(2'd0, 8'h04);
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (scl_line) held = 1'b0;
            end
            rd(2'd2, v);
            chk(held && v == exp_addr_code(addr_b[0], nk != 0), "R5 clock held while flag set",
                v, exp_addr_code(addr_b[0], nk != 0));
            rd(2'd0, v);
            chk(v[2] == 1'b1, "R5 writing 1 keeps flag", v[2], 1);
        end
        if (addr_b[0]) begin
            s0 = stop_cnt;
            wr(2'd0, {4'b0, ackb, 3'b000});
            repeat (120) @(negedge clk);
            rd(2'd0, v);
            chk(stop_cnt == s0 + 1 && scl_line && sda_line && !v[2],
                "R3 read address only stops", stop_cnt - s0, 1);
            in_wait = 1'b0;
            return;
        end
        for (int i = 0; i < nbytes; i++) begin
            d = 8'($urandom);
            wr(2'd1, d);
            wr(2'd0, {4'b0, ackb, 3'b000});
            wait_irq("R4 data event");
            expect_status(exp_data_code(nk != i + 1), "R4 data status");
            chk(cap[i+1] == d, "R4 data bits", cap[i+1], d);
        end
        if (fin == 0) begin
            finish_stop(ackb);
            in_wait = 1'b0;
        end else if (fin == 1) begin
            wr(2'd0, {4'b0, ackb, 3'b001});
            wait_irq("R6 repeated start");
            expect_status(8'h10, "R6 repeated start status");
            in_wait = 1'b1;
        end else begin
            s0 = stop_cnt;
            wr(2'd0, {4'b0, ackb, 3'b011});
            wait_irq("R6 stop then start");
            expect_status(8'h08, "R6 stop then start status");
            chk(stop_cnt == s0 + 1, "R6 stop before start", stop_cnt - s0, 1);
            in_wait = 1'b1;
        end
    endtask

    task automatic lose_arbitration(input string req);
        logic [7:0] v;
        wr(2'd0, 8'h01);
        wait_irq("R2 start before loss");
        rival_arm = 1'b1;
        rival_bit = 2;
        nack_idx = -1;
        wr(2'd1, 8'hA6);
        wr(2'd0, 8'h00);
        wait_irq("R8 loss event");
        rd(2'd2, v);
        chk(v == 8'h38 && !dut_scl_low && !dut_sda_low, req, v, 8'h38);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit in_wait;
        int seed;
        seed = int'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) cap[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == 8'h00, "R1 control reset", v, 8'h00);
        rd(2'd2, v); chk(v == 8'hF8, "R1 status reset", v, 8'hF8);
        chk(!dut_scl_low && !dut_sda_low, "R1 lines released", {dut_scl_low, dut_sda_low}, 0);
        // R10 register access
        wr(2'd2, 8'h55);
        rd(2'd2, v); chk(v == 8'hF8, "R10 status read-only", v, 8'hF8);
        rd(2'd3, v); chk(v == 8'h00, "R10 spare offset", v, 8'h00);
        wr(2'd0, 8'h08);
        rd(2'd0, v); chk(v == 8'h08, "R10 ack bit stored", v, 8'h08);
        repeat (50) @(negedge clk);
        chk(scl_line && sda_line, "R10 ack bit no bus effect", {scl_line, sda_line}, 3);

        // R2 first start
        wr(2'd0, 8'h01);
        wait_irq("R2 start event");
        expect_status(8'h08, "R2 start status");

        // directed: write address with NACK on a data byte, hold check, stop
        txn(8'hA0, 2, 2, 0, 1'b0, 1'b1, in_wait);

        // constrained random transfers
        in_wait = 1'b0;
        for (int t = 0; t < 14; t++) begin
            logic [7:0] a;
            int nb, nk, fin;
            if (!in_wait) begin
                wr(2'd0, 8'h01);
                wait_irq("R2 start event");
                expect_status(8'h08, "R2 start status");
            end
            a = 8'($urandom);
            a[0] = (($urandom % 4) == 0);
            nb = int'($urandom % 4);
            nk = int'($urandom % 6);
            fin = (t == 13) ? 0 : int'($urandom % 3);
            txn(a, nb, nk, fin, 1'($urandom), 1'b0, in_wait);
        end
        if (in_wait) finish_stop(1'b0);

        // R8/R9 loss then start when bus frees
        lose_arbitration("R8 lost status and release");
        wr(2'd0, 8'h01);
        repeat (100) @(negedge clk);
        rd(2'd0, v);
        chk(!v[2] && !dut_scl_low, "R9 no start while bus busy", v[2], 0);
        rival_low = 1'b0;
        wait_irq("R9 start after bus free");
        expect_status(8'h08, "R9 start after bus free");
        txn(8'h50, 1, -1, 0, 1'b0, 1'b0, in_wait);

        // R8/R9 loss then stay idle
        lose_arbitration("R8 lost status second");
        wr(2'd0, 8'h00);
        rival_low = 1'b0;
        repeat (300) @(negedge clk);
        rd(2'd0, v);
        chk(!v[2] && scl_line && sda_line, "R9 idle after loss", v, 0);
        rd(2'd2, v);
        chk(v == 8'h38, "R9 status kept", v, 8'h38);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule